// File: doc/BRIEF.md
# Codec Presence Detector with Wake Interrupt

This block watches the serial data input lines of an audio link and records, for each line, whether a codec announced itself during a connect frame. A codec announces itself by holding its data line high in the final bit-clock cycle of the frame sync pulse. Only the first frames after the link leaves reset are connect frames. A line that shows this signal gets a sticky state-change bit. Software clears these bits, releases the link reset, and then reads back which lines carry a codec. Bits that were set before a later attach stay set, so a codec added afterwards shows up as one more set bit.

Each line also has a wake enable bit. When a line's status bit and its wake enable are both set, the block drives a level interrupt. Software uses this to learn of a codec that attaches to a line that was empty. A small write port sets the wake enables and clears status bits with write-one-to-clear. A frame counter runs from the release of the link reset. It selects the connect frames and is also brought out for the frame sequencing logic that follows.

Top module: `cpd_presence`

## Requirements
- R1: While the controller reset `rstN` is low, `stateStatus` is all zeros, every wake enable is zero (so `irq` is 0), and `frameNum` is 0.
- R2: If `sdiIn[i]` is 1 in the last cycle where `frameSync` is high, and that frame is a connect frame, then `stateStatus[i]` becomes 1. It is visible after the second rising clock edge that follows that cycle.
- R3: A data line that is high in any cycle other than the last cycle of a connect frame's sync pulse does not set its status bit. This covers earlier sync cycles and cycles outside sync.
- R4: Frames are numbered from 0 starting at the first sync rising edge after link reset release. Only frames 0 to CONNECT_FRAMES-1 (default 2) are connect frames. Later frames never set a status bit.
- R5: A write with `wrEn`=1 and `wrSel`=0 clears every status bit where `wrData` is 1 and leaves the other bits unchanged.
- R6: If a detection and a clear hit the same status bit in the same cycle, the detection wins and the bit ends up set.
- R7: A write with `wrSel`=1 loads the wake enable vector from `wrData`. `irq` is the OR over all lines of status AND wake enable. It falls as soon as the contributing bits are cleared or disabled.
- R8: While `linkRstN` is low, no line is sampled. The status bits keep their values unless software writes them, and `frameNum` is 0.
- R9: `frameNum` counts sync rising edges since link reset release. It saturates at 2**CNT_W-1 (default 15).
- R10: Once set, a status bit stays set through later frames until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rstN | input | 1 | Controller reset, active low, asynchronous; clears everything |
| linkRstN | input | 1 | Link reset, active low, synchronous; resets frame tracking only |
| frameSync | input | 1 | Frame sync from the link; high for the sync pulse of each frame |
| sdiIn | input | LINES | Serial data input lines, one per codec slot |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = status clear (write one to clear), 1 = wake enables |
| wrData | input | LINES | Write data, one bit per line |
| stateStatus | output | LINES | Sticky per-line state-change status |
| irq | output | 1 | Level wake interrupt |
| frameNum | output | CNT_W | Frames seen since link reset release, saturating |

## Verification
The assertions check the following on every cycle:
- A status bit only rises for a line that was high two cycles earlier.
- A detected line always ends up set, even when a clear hits it in the same cycle.
- A clear that does not collide with a detection removes the written bits.
- Bits stay set when no write happens, and they do not move during link reset.
- The frame counter only moves up by one.
- The interrupt only falls after a write.

Some behaviour depends on the position of a frame in the sequence, so only the bench scenarios show it:
- Frames after the connect window are ignored.
- Noise on early sync cycles is not taken as a codec.
- The detection latency is exact.
- The frame counter saturates.
- Status survives a link reset.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

  // Strobes handed from frame control to the status datapath
  typedef struct packed {
    logic frameStart;   // first cycle of a sync pulse
    logic sampleNow;    // the registered data bits belong to the last sync cycle of a connect frame
    logic linkLive;     // link out of reset
  } ctrlStrb_t;

  // Write-port targets
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_WAKE   = 1'b1
  } wrSel_e;

endpackage

// File: rtl/cpd_frame_ctrl.sv
module cpd_frame_ctrl
  import cpd_pkg::*;
#(
  parameter int CONNECT_FRAMES = 2,
  parameter int CNT_W          = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linkRstN,
  input  logic             frameSync,
  output ctrlStrb_t        strb,
  output logic [CNT_W-1:0] frameNum
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CONN_LIM = CNT_W'(CONNECT_FRAMES);

  logic             syncQ;
  logic             connectQ;
  logic [CNT_W-1:0] frameCnt;
  logic             syncRise;
  logic             syncFall;

  // Edges of the sync pulse, seen against the copy taken at the previous edge
  assign syncRise = linkRstN & frameSync & ~syncQ;
  assign syncFall = linkRstN & syncQ & ~frameSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 1'b0;
      connectQ <= 1'b0;
      frameCnt <= '0;
    end else if (!linkRstN) begin
      syncQ    <= 1'b0;
      connectQ <= 1'b0;
      frameCnt <= '0;
    end else begin
      syncQ <= frameSync;
      if (syncRise) begin
        // frame index before the increment decides connect membership
        connectQ <= (frameCnt < CONN_LIM);
        if (frameCnt != CNT_MAX) begin
          frameCnt <= frameCnt + CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    strb            = '0;
    strb.frameStart = syncRise;
    strb.sampleNow  = syncFall & connectQ;
    strb.linkLive   = linkRstN;
  end

  assign frameNum = frameCnt;

endmodule

// File: rtl/cpd_status_dp.sv
module cpd_status_dp
  import cpd_pkg::*;
#(
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [LINES-1:0] sdiIn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [LINES-1:0] wrData,
  output logic [LINES-1:0] stateStatus,
  output logic             irq
);

  logic [LINES-1:0] sdiQ;
  logic [LINES-1:0] hitVec;
  logic [LINES-1:0] clrVec;
  logic [LINES-1:0] wakeEn;
  logic             wrStatus;
  logic             wrWake;

  assign wrStatus = wrEn & (wrSel == SEL_STATUS);
  assign wrWake   = wrEn & (wrSel == SEL_WAKE);

  // Data lines captured alongside the sync copy in frame control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdiQ <= '0;
    end else if (!strb.linkLive) begin
      sdiQ <= '0;
    end else begin
      sdiQ <= sdiIn;
    end
  end

  assign hitVec = strb.sampleNow ? sdiQ : '0;
  assign clrVec = wrStatus ? wrData : '0;

  // One sticky bit per line; detection outranks a clear in the same cycle
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stateStatus[i] <= 1'b0;
      end else if (hitVec[i]) begin
        stateStatus[i] <= 1'b1;
      end else if (clrVec[i]) begin
        stateStatus[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeEn <= '0;
    end else if (wrWake) begin
      wakeEn <= wrData;
    end
  end

  assign irq = |(stateStatus & wakeEn);

endmodule

// File: rtl/cpd_presence.sv
module cpd_presence
  import cpd_pkg::*;
#(
  parameter int LINES          = 4,
  parameter int CONNECT_FRAMES = 2,
  parameter int CNT_W          = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linkRstN,
  input  logic             frameSync,
  input  logic [LINES-1:0] sdiIn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [LINES-1:0] wrData,
  output logic [LINES-1:0] stateStatus,
  output logic             irq,
  output logic [CNT_W-1:0] frameNum
);

  ctrlStrb_t ctrlStrb;

  cpd_frame_ctrl #(
    .CONNECT_FRAMES(CONNECT_FRAMES),
    .CNT_W         (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .linkRstN (linkRstN),
    .frameSync(frameSync),
    .strb     (ctrlStrb),
    .frameNum (frameNum)
  );

  cpd_status_dp #(
    .LINES(LINES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (ctrlStrb),
    .sdiIn      (sdiIn),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrData     (wrData),
    .stateStatus(stateStatus),
    .irq        (irq)
  );

endmodule

// File: rtl/cpd_checker.sv
module cpd_checker
  import cpd_pkg::*;
#(
  parameter int LINES = 4,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             linkRstN,
  input logic [LINES-1:0] sdiIn,
  input logic             wrEn,
  input logic             wrSel,
  input logic [LINES-1:0] wrData,
  input logic [LINES-1:0] stateStatus,
  input logic             irq,
  input logic [CNT_W-1:0] frameNum,
  input ctrlStrb_t        strb
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!rstN || ((stateStatus == '0) && !irq && (frameNum == '0))));

  // R2
  rise_needs_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateStatus & ~$past(stateStatus) & ~$past(sdiIn, 2)) == '0));

  // R6
  detect_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleNow |=> ((stateStatus & $past(sdiIn, 2)) == $past(sdiIn, 2)));

  // R5
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel && !strb.sampleNow) |=> ((stateStatus & $past(wrData)) == '0));

  // R10
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((stateStatus & $past(stateStatus)) == $past(stateStatus)));

  // R8
  link_reset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!linkRstN && !wrEn) |=> (stateStatus == $past(stateStatus)));

  // R8
  link_reset_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    !linkRstN |=> (frameNum == '0));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkRstN && $past(linkRstN) && (frameNum != $past(frameNum)))
      |-> (frameNum == $past(frameNum) + CNT_W'(1)));

  // R7
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(wrEn));

endmodule

bind cpd_presence cpd_checker #(
  .LINES(LINES),
  .CNT_W(CNT_W)
) u_cpd_checker (
  .clk        (clk),
  .rstN       (rstN),
  .linkRstN   (linkRstN),
  .sdiIn      (sdiIn),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .wrData     (wrData),
  .stateStatus(stateStatus),
  .irq        (irq),
  .frameNum   (frameNum),
  .strb       (ctrlStrb)
);

// File: tb/test_cpd_presence.sv
module test_cpd_presence;

  localparam int L    = 4;
  localparam int CF   = 2;
  localparam int CW   = 4;
  localparam int FMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN, linkRstN, frameSync, wrEn, wrSel, irq;
  logic [L-1:0]  sdiIn, wrData, stateStatus;
  logic [CW-1:0] frameNum;

  always #5 clk = ~clk;

  cpd_presence #(.LINES(L), .CONNECT_FRAMES(CF), .CNT_W(CW)) i_cpd_presence (
    .clk(clk), .rstN(rstN), .linkRstN(linkRstN), .frameSync(frameSync),
    .sdiIn(sdiIn), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .stateStatus(stateStatus), .irq(irq), .frameNum(frameNum)
  );

  int vectors = 0;
  int errors  = 0;
  logic [L-1:0] expStat = '0;
  logic [L-1:0] expWake = '0;
  int expFrame = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nextFrame(input int f);
    return (f < FMAX) ? f + 1 : f;
  endfunction

  function automatic logic expIrq(input logic [L-1:0] s, input logic [L-1:0] w);
    return |(s & w);
  endfunction

  task automatic checkAll(input string req);
    chk({req, " status"}, 32'(stateStatus), 32'(expStat));
    chk({req, " irq"}, 32'(irq), 32'(expIrq(expStat, expWake)));
    chk({req, " frameNum"}, 32'(frameNum), 32'(expFrame));
  endtask

  // register write, visible at the following negedge
  task automatic regWrite(input logic sel, input logic [L-1:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    if (sel) expWake = data;
    else     expStat = expStat & ~data;
  endtask

  // one frame: four sync cycles, then idle cycles with random line noise
  task automatic doFrame(input logic [L-1:0] lastSdi, input logic [L-1:0] clrMask,
                         input bit noisy, input int idle);
    bit conn;
    conn = (expFrame < CF);
    expFrame = nextFrame(expFrame);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      frameSync = 1'b1;
      wrEn = 1'b0;
      sdiIn = (c == 3) ? lastSdi : (noisy ? L'($urandom) : '0);
    end
    @(negedge clk);
    frameSync = 1'b0;
    sdiIn = L'($urandom);
    if (clrMask != '0) begin
      wrEn = 1'b1; wrSel = 1'b0; wrData = clrMask;
    end
    expStat = (expStat & ~clrMask) | (conn ? lastSdi : '0);
    for (int c = 0; c < idle; c++) begin
      @(negedge clk);
      wrEn = 1'b0;
      sdiIn = L'($urandom);
    end
  endtask

  task automatic linkReset(input int cycles, input bit clearInside);
    @(negedge clk);
    linkRstN = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      frameSync = 1'($urandom);
      sdiIn = L'($urandom);
      expFrame = 0;
      chk("R8 held status", 32'(stateStatus), 32'(expStat));
      chk("R8 count zero", 32'(frameNum), 32'd0);
    end
    frameSync = 1'b0;
    if (clearInside) regWrite(1'b0, expStat);
    @(negedge clk);
    linkRstN = 1'b1;
    expFrame = 0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    vectors++;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; linkRstN = 1'b0; frameSync = 1'b0; sdiIn = '0;
    wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
    repeat (3) @(negedge clk);
    checkAll("R1 reset");
    rstN = 1'b1;
    regWrite(1'b0, '1);
    repeat (2) @(negedge clk);
    linkRstN = 1'b1;

    // R2 exact latency, frame 0
    expFrame = 1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      frameSync = 1'b1;
      sdiIn = (c == 3) ? 4'b0101 : 4'b0000;
    end
    @(negedge clk);
    frameSync = 1'b0; sdiIn = 4'b0000;
    chk("R2 one edge after last sync", 32'(stateStatus), 32'h0);
    @(negedge clk);
    chk("R2 two edges after last sync", 32'(stateStatus), 32'h5);
    expStat = 4'b0101;
    checkAll("R2 frame0");

    // R3: noise on early sync cycles and idle, only the last cycle counts
    doFrame(4'b1000, '0, 1'b1, 3);
    checkAll("R3 noisy connect frame");

    // R4: third frame is outside the connect window
    doFrame(4'b1111, '0, 1'b1, 3);
    checkAll("R4 non-connect frame");

    // R10: sticky across quiet frames
    doFrame(4'b0000, '0, 1'b0, 2);
    doFrame(4'b0000, '0, 1'b0, 2);
    checkAll("R10 sticky");

    // R7: wake gating and level drop
    regWrite(1'b1, 4'b0010);
    checkAll("R7 wake on empty line");
    regWrite(1'b1, 4'b0100);
    checkAll("R7 wake on set line");
    // R5: partial W1C
    regWrite(1'b0, 4'b0100);
    checkAll("R5 R7 clear drops irq");

    // R8: status survives link reset
    linkReset(6, 1'b0);
    checkAll("R8 after release");
    // R6: clear collides with detection on the same bit
    regWrite(1'b1, 4'b0011);
    doFrame(4'b0010, 4'b1011, 1'b0, 2);
    checkAll("R6 detect beats clear");

    // R9: saturation of the frame counter
    for (int f = 0; f < FMAX + 3; f++) doFrame(L'($urandom), '0, 1'b1, 1);
    checkAll("R9 saturated count");

    // random mix
    for (int it = 0; it < 60; it++) begin
      int pick;
      pick = int'($urandom % 8);
      if (pick == 0)      linkReset(1 + int'($urandom % 4), 1'($urandom));
      else if (pick == 1) regWrite(1'b0, L'($urandom));
      else if (pick == 2) regWrite(1'b1, L'($urandom));
      else doFrame(L'($urandom), ((pick == 3) ? L'($urandom) : '0), 1'($urandom),
                   1 + int'($urandom % 3));
      checkAll("R2 R4 R5 R7 random");
    end

    rstN = 1'b0;
    @(negedge clk);
    expStat = '0; expWake = '0; expFrame = 0;
    checkAll("R1 late reset");
    summary();
  end

endmodule